// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a linear address for an address-generation pipeline. It has two modes, chosen by `prot_en`. In the real-address mode a 16-bit segment value is combined with a 16-bit offset into a 20-bit address. In the protected mode each segment register holds a 16-bit selector. Loading a selector fetches an 8-byte descriptor from the global or the local descriptor table through a 32-bit memory read port. The descriptor is kept in a hidden cache beside the register. After that, translations add the cached 32-bit base to the 32-bit offset and never touch memory.

The global table is located by a base/size register that is written directly. The local table is located indirectly: its register takes a selector, and that selector is looked up in the global table. The fetched descriptor gives the local table's base and limit. A selector whose descriptor would lie past the end of its table raises a one-cycle fault and leaves every cache as it was. Limits and attribute bits of segment descriptors are reported next to each translated address but are not enforced here.

Top module: `sat_unit`

## Requirements
- R1: With `prot_en` low, a write to a segment register stores the value V, and a translation returns `(V*16 + off[15:0]) mod 2^20` with bits 31:20 zero; offset bits 31:16 have no effect. The limit reported is 0xFFFF with attributes 0. The write also sets the register's cached base to V*16.
- R2: With `prot_en` high, a translation returns `(cached base + off) mod 2^32`, with the cached limit and attributes alongside.
- R3: A protected-mode selector load reads two 32-bit words, at table base + index*8 and then at that address + 4. Index = selector bits 15:3, and selector bits 1:0 are ignored. The first word is the segment base. In the second word, bits 19:0 are the limit and bits 31:20 are the attributes. A read is held with a stable address until `mem_ack`.
- R4: Selector bit 2 picks the table for a segment-register load: 0 uses the global table, and 1 uses the local table, whose base comes from the descriptor last loaded through the local table register.
- R5: A local table register load always looks its selector up in the global table, whatever bit 2 holds.
- R6: `busy` rises the cycle after an accepted load and falls when the descriptor is written (two cycles with a memory that acknowledges every cycle). Translation requests and loads made while `busy` is high are dropped: no `xl_valid` is produced and no state changes.
- R7: If index*8+7 exceeds the global size (global table) or the local limit (local table), `fault` is high for exactly the next cycle. No memory read is made and all caches keep their contents. index*8+7 equal to the bound is accepted.
- R8: Translations read only the cached descriptor. Changing table memory after a load does not change results, and translation issues no memory read.
- R9: After reset, `busy`, `fault`, `xl_valid` and `mem_rd` are low, every cached base is 0, the global size is 0 and the local limit is 0.
- R10: A request accepted while not busy gives `xl_valid` high, with its result, in the following cycle only.
- R11: When a local table register load and a segment-register write arrive in the same cycle, the local table load is taken and the segment write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_en | input | 1 | 1 = protected mode, 0 = real-address mode |
| gtr_wr | input | 1 | Write global table base and size |
| gtr_base | input | 32 | Global table base |
| gtr_size | input | 16 | Global table size (last valid byte offset) |
| ltr_wr | input | 1 | Load local table register selector |
| ltr_sel | input | 16 | Local table selector |
| seg_wr | input | 1 | Write a segment register |
| seg_idx | input | 2 | Segment register number |
| seg_val | input | 16 | Segment value or selector |
| xl_req | input | 1 | Translation request |
| xl_seg | input | 2 | Segment register used for translation |
| xl_off | input | 32 | Offset |
| xl_valid | output | 1 | Translation result valid |
| xl_addr | output | 32 | Linear address |
| xl_limit | output | 20 | Cached limit of the segment used |
| xl_attr | output | 12 | Cached attribute bits of the segment used |
| busy | output | 1 | Descriptor fetch in progress |
| fault | output | 1 | Selector rejected by table bound |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read data valid; ends the current read |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong cached base or a mis-targeted fill stays hidden until the affected register is next used for a translation, and then it appears at `xl_addr` one cycle after the request. For that reason every register is translated after each load, fault and dropped write. A wrong fetch address shows up on `mem_addr` in the cycle after the load is accepted. A wrong bound decision shows up as `fault` or `busy` in that same cycle. The reference model tracks busy, fault and every translation result cycle by cycle, so a stall that is one cycle too long or too short is reported at once.

// File: rtl/sat_pkg.sv
// Shared types for the segmented address translation unit.
// Assumes 32-bit memory words and 8-byte descriptors made of two words.
package sat_pkg;

    // Cached descriptor: base from the low word, limit and attributes from the high word.
    typedef struct packed {
        logic [11:0] attr;
        logic [19:0] limit;
        logic [31:0] base;
    } desc_t;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_LO   = 2'd1,
        F_HI   = 2'd2
    } fetch_st_t;

    localparam int unsigned   DESC_SHIFT = 3;          // descriptor size is 1 << DESC_SHIFT bytes
    localparam logic [19:0]   REAL_LIMIT = 20'h0FFFF;  // limit reported in real-address mode

endpackage

// File: rtl/sat_bound_chk.sv
// Table selection and bound check for a selector load.
// Computes the descriptor address in the chosen table and flags an index
// whose last descriptor byte lies beyond the table bound. Purely combinational.
module sat_bound_chk #(
    parameter int AW   = 32,
    parameter int SELW = 16,
    parameter int SZW  = 16,
    parameter int LIMW = 20,
    localparam int IXW = SELW - sat_pkg::DESC_SHIFT
) (
    input  logic [IXW-1:0]  idx,
    input  logic            use_local,
    input  logic [AW-1:0]   gbase,
    input  logic [SZW-1:0]  gsize,
    input  logic [AW-1:0]   lbase,
    input  logic [LIMW-1:0] llimit,
    output logic [AW-1:0]   desc_addr,
    output logic            oob
);
    logic [SELW-1:0] byte_off;
    logic [SELW-1:0] last_byte;

    // Byte offset of the descriptor and of its final byte inside the table.
    always_comb begin
        byte_off  = {idx, {sat_pkg::DESC_SHIFT{1'b0}}};
        last_byte = {idx, {sat_pkg::DESC_SHIFT{1'b1}}};
    end

    // Pick the table and compare against its bound.
    always_comb begin
        if (use_local) begin
            desc_addr = lbase + AW'(byte_off);
            oob       = LIMW'(last_byte) > llimit;
        end else begin
            desc_addr = gbase + AW'(byte_off);
            oob       = SZW'(last_byte) > gsize;
        end
    end
endmodule

// File: rtl/sat_fetch.sv
// Two-word descriptor fetch sequencer.
// On start, reads the low word then the high word over a request/ack port.
// The request is held with a stable address until acknowledged; done is
// high in the cycle the high word arrives, with desc_out valid then.
module sat_fetch #(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        start_addr,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 mem_rd,
    output logic [AW-1:0]        mem_addr,
    output logic                 busy,
    output logic                 done,
    output sat_pkg::desc_t       desc_out
);
    import sat_pkg::*;

    fetch_st_t       st_q;
    logic [AW-1:0]   addr_q;
    logic [31:0]     lo_q;

    // Sequence the two reads and keep the low word until the high one arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= F_IDLE;
            addr_q <= '0;
            lo_q   <= '0;
        end else begin
            case (st_q)
                F_IDLE: if (start) begin
                    addr_q <= start_addr;
                    st_q   <= F_LO;
                end
                F_LO: if (mem_ack) begin
                    lo_q   <= mem_rdata;
                    addr_q <= addr_q + AW'(4);
                    st_q   <= F_HI;
                end
                F_HI: if (mem_ack) begin
                    st_q <= F_IDLE;
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

    // Port outputs and assembled descriptor.
    always_comb begin
        busy     = (st_q != F_IDLE);
        mem_rd   = busy;
        mem_addr = addr_q;
        done     = (st_q == F_HI) && mem_ack;
        desc_out = '{attr: mem_rdata[31:20], limit: mem_rdata[19:0], base: lo_q};
    end
endmodule

// File: rtl/sat_seg_file.sv
// Segment registers with their hidden descriptor caches.
// One write port: a real-address write stores the value and a base of
// value*16; a fill stores a selector with its fetched descriptor.
// One combinational read port for translation.
module sat_seg_file #(
    parameter int NSEG = 4,
    parameter int SW   = 2,
    parameter int SELW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                leg_we,
    input  logic                fill_we,
    input  logic [SW-1:0]       we_idx,
    input  logic [SELW-1:0]     we_sel,
    input  sat_pkg::desc_t      fill_desc,
    input  logic [SW-1:0]       rd_idx,
    output logic [SELW-1:0]     rd_sel,
    output sat_pkg::desc_t      rd_desc
);
    import sat_pkg::*;

    logic [SELW-1:0] sel_all  [NSEG];
    desc_t           desc_all [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SELW-1:0] sel_r;
        desc_t           desc_r;

        // Update this register on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_r  <= '0;
                desc_r <= '0;
            end else if (we_idx == SW'(g)) begin
                if (leg_we) begin
                    sel_r  <= we_sel;
                    desc_r <= '{attr: 12'h000, limit: REAL_LIMIT, base: 32'({we_sel, 4'b0000})};
                end else if (fill_we) begin
                    sel_r  <= we_sel;
                    desc_r <= fill_desc;
                end
            end
        end

        assign sel_all[g]  = sel_r;
        assign desc_all[g] = desc_r;
    end

    // Read port for the translation path.
    always_comb begin
        rd_sel  = sel_all[rd_idx];
        rd_desc = desc_all[rd_idx];
    end
endmodule

// File: rtl/sat_unit.sv
// Segmented address translation unit, top level.
// Holds the global table register and the local table cache, accepts
// selector loads (checking the table bound, then fetching the descriptor)
// and translates offsets with a one-cycle registered result.
// Assumes prot_en is steady while a fetch is in progress.
module sat_unit #(
    parameter int NSEG = 4,
    parameter int AW   = 32,
    parameter int SELW = 16,
    parameter int SZW  = 16,
    localparam int SW  = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int IXW = SELW - sat_pkg::DESC_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_en,
    input  logic             gtr_wr,
    input  logic [AW-1:0]    gtr_base,
    input  logic [SZW-1:0]   gtr_size,
    input  logic             ltr_wr,
    input  logic [SELW-1:0]  ltr_sel,
    input  logic             seg_wr,
    input  logic [SW-1:0]    seg_idx,
    input  logic [SELW-1:0]  seg_val,
    input  logic             xl_req,
    input  logic [SW-1:0]    xl_seg,
    input  logic [AW-1:0]    xl_off,
    output logic             xl_valid,
    output logic [AW-1:0]    xl_addr,
    output logic [19:0]      xl_limit,
    output logic [11:0]      xl_attr,
    output logic             busy,
    output logic             fault,
    output logic             mem_rd,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata
);
    import sat_pkg::*;

    logic [AW-1:0]   gbase_q;
    logic [SZW-1:0]  gsize_q;
    logic [AW-1:0]   lbase_q;
    logic [19:0]     llim_q;
    logic            pend_ltr_q;
    logic [SW-1:0]   pend_idx_q;
    logic [SELW-1:0] pend_sel_q;
    logic            fault_q;
    logic            xl_valid_q;
    logic [AW-1:0]   xl_addr_q;
    logic [19:0]     xl_limit_q;
    logic [11:0]     xl_attr_q;

    logic            load_any, idle, start, oob, done, leg_we, fill_we, xl_go;
    logic [SELW-1:0] ld_sel;
    logic            ld_local;
    logic [AW-1:0]   desc_addr;
    desc_t           fetched;
    logic [SELW-1:0] rd_sel;
    desc_t           rd_desc;
    logic [19:0]     real_lin;

    // Load arbitration: the local table load wins over a segment write.
    always_comb begin
        idle     = !busy;
        load_any = ltr_wr || (seg_wr && prot_en);
        ld_sel   = ltr_wr ? ltr_sel : seg_val;
        ld_local = !ltr_wr && ld_sel[2];
        start    = load_any && idle && !oob;
        leg_we   = seg_wr && !prot_en && !ltr_wr && idle;
        fill_we  = done && !pend_ltr_q;
        xl_go    = xl_req && idle;
        real_lin = {rd_sel, 4'b0000} + {4'b0000, xl_off[15:0]};
    end

    sat_bound_chk #(.AW(AW), .SELW(SELW), .SZW(SZW), .LIMW(20)) u_bound (
        .idx       (ld_sel[SELW-1:DESC_SHIFT]),
        .use_local (ld_local),
        .gbase     (gbase_q),
        .gsize     (gsize_q),
        .lbase     (lbase_q),
        .llimit    (llim_q),
        .desc_addr (desc_addr),
        .oob       (oob)
    );

    sat_fetch #(.AW(AW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (desc_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (done),
        .desc_out   (fetched)
    );

    sat_seg_file #(.NSEG(NSEG), .SW(SW), .SELW(SELW)) u_segs (
        .clk       (clk),
        .rst_n     (rst_n),
        .leg_we    (leg_we),
        .fill_we   (fill_we),
        .we_idx    (leg_we ? seg_idx : pend_idx_q),
        .we_sel    (leg_we ? seg_val : pend_sel_q),
        .fill_desc (fetched),
        .rd_idx    (xl_seg),
        .rd_sel    (rd_sel),
        .rd_desc   (rd_desc)
    );

    // Table registers: global written directly, local filled by a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gbase_q <= '0;
            gsize_q <= '0;
            lbase_q <= '0;
            llim_q  <= '0;
        end else begin
            if (gtr_wr) begin
                gbase_q <= gtr_base;
                gsize_q <= gtr_size;
            end
            if (done && pend_ltr_q) begin
                lbase_q <= fetched.base;
                llim_q  <= fetched.limit;
            end
        end
    end

    // Remember the destination of an accepted load; flag a rejected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ltr_q <= 1'b0;
            pend_idx_q <= '0;
            pend_sel_q <= '0;
            fault_q    <= 1'b0;
        end else begin
            fault_q <= load_any && idle && oob;
            if (start) begin
                pend_ltr_q <= ltr_wr;
                pend_idx_q <= seg_idx;
                pend_sel_q <= ld_sel;
            end
        end
    end

    // Registered translation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid_q <= 1'b0;
            xl_addr_q  <= '0;
            xl_limit_q <= '0;
            xl_attr_q  <= '0;
        end else begin
            xl_valid_q <= xl_go;
            if (xl_go) begin
                if (prot_en) begin
                    xl_addr_q  <= rd_desc.base + xl_off;
                    xl_limit_q <= rd_desc.limit;
                    xl_attr_q  <= rd_desc.attr;
                end else begin
                    xl_addr_q  <= AW'(real_lin);
                    xl_limit_q <= REAL_LIMIT;
                    xl_attr_q  <= 12'h000;
                end
            end
        end
    end

    assign xl_valid = xl_valid_q;
    assign xl_addr  = xl_addr_q;
    assign xl_limit = xl_limit_q;
    assign xl_attr  = xl_attr_q;
    assign fault    = fault_q;
endmodule

// File: rtl/sat_unit_chk.sv
// Port-level properties of sat_unit, attached by bind.
module sat_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prot_en,
    input logic          ltr_wr,
    input logic          seg_wr,
    input logic          xl_req,
    input logic          xl_valid,
    input logic [AW-1:0] xl_addr,
    input logic          busy,
    input logic          fault,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack
);
    p_stall_xl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && xl_req |=> !xl_valid);

    p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ltr_wr || (seg_wr && prot_en)));

    p_xl_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req && !busy |=> xl_valid);

    p_xl_only_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> !xl_valid);

    p_fault_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !mem_rd);

    p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(ltr_wr || (seg_wr && prot_en)));

    p_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));

    p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) && mem_ack |=> mem_rd && (mem_addr == $past(mem_addr) + AW'(4)));

    p_real_20bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en && xl_req && !busy |=> xl_addr[AW-1:20] == '0);
endmodule

bind sat_unit sat_unit_chk #(.AW(AW)) u_sat_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_en  (prot_en),
    .ltr_wr   (ltr_wr),
    .seg_wr   (seg_wr),
    .xl_req   (xl_req),
    .xl_valid (xl_valid),
    .xl_addr  (xl_addr),
    .busy     (busy),
    .fault    (fault),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/sat_unit_test.sv
// Bench for sat_unit: behavioural reference model compared every cycle,
// plus directed checks on fetch addresses and translation results.
module sat_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_en = 1'b0, gtr_wr = 1'b0, ltr_wr = 1'b0, seg_wr = 1'b0, xl_req = 1'b0;
    logic [31:0] gtr_base = '0, xl_off = '0;
    logic [15:0] gtr_size = '0, ltr_sel = '0, seg_val = '0;
    logic [1:0]  seg_idx = '0, xl_seg = '0;
    logic        xl_valid, busy, fault, mem_rd;
    logic [31:0] xl_addr, mem_addr;
    logic [19:0] xl_limit;
    logic [11:0] xl_attr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int tests = 0, fails = 0;
    bit finished = 0;
    string tag = "R9";

    logic [31:0] mem [0:1023];
    logic [31:0] rd_log [$];
    int          rd_count = 0;

    always #10 clk = ~clk;

    sat_unit uut (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .gtr_wr(gtr_wr), .gtr_base(gtr_base),
        .gtr_size(gtr_size), .ltr_wr(ltr_wr), .ltr_sel(ltr_sel), .seg_wr(seg_wr),
        .seg_idx(seg_idx), .seg_val(seg_val), .xl_req(xl_req), .xl_seg(xl_seg),
        .xl_off(xl_off), .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_limit(xl_limit),
        .xl_attr(xl_attr), .busy(busy), .fault(fault), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory: acknowledges any pending read half a cycle later.
    always @(negedge clk) begin
        mem_ack   = mem_rd;
        mem_rdata = mem[mem_addr[11:2]];
        if (mem_rd) begin
            rd_log.push_back(mem_addr);
            rd_count++;
        end
    end

    // Reference model state.
    logic [15:0] m_val  [4];
    logic [31:0] m_base [4];
    logic [19:0] m_lim  [4];
    logic [11:0] m_attr [4];
    logic [31:0] m_gbase, m_lbase;
    logic [15:0] m_gsize;
    logic [19:0] m_llim;
    int          m_busy;
    bit          p_ltr;
    logic [1:0]  p_idx;
    logic [15:0] p_sel;
    logic [31:0] p_lo, p_hi;
    bit          e_valid, e_fault;
    logic [31:0] e_addr;
    logic [19:0] e_lim;
    logic [11:0] e_attr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_val[i] = '0; m_base[i] = '0; m_lim[i] = '0; m_attr[i] = '0;
            end
            m_gbase = '0; m_gsize = '0; m_lbase = '0; m_llim = '0;
            m_busy = 0; e_valid = 0; e_fault = 0; e_addr = '0; e_lim = '0; e_attr = '0;
        end else begin
            int b;
            b = m_busy;
            e_valid = (xl_req && b == 0);
            if (e_valid) begin
                if (prot_en) begin
                    e_addr = m_base[xl_seg] + xl_off;
                    e_lim  = m_lim[xl_seg];
                    e_attr = m_attr[xl_seg];
                end else begin
                    e_addr = ((32'(m_val[xl_seg]) << 4) + 32'(xl_off[15:0])) & 32'h000F_FFFF;
                    e_lim  = 20'h0FFFF;
                    e_attr = '0;
                end
            end
            e_fault = 0;
            if (b > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    if (p_ltr) begin
                        m_lbase = p_lo; m_llim = p_hi[19:0];
                    end else begin
                        m_val[p_idx] = p_sel; m_base[p_idx] = p_lo;
                        m_lim[p_idx] = p_hi[19:0]; m_attr[p_idx] = p_hi[31:20];
                    end
                end
            end else if (ltr_wr || (seg_wr && prot_en)) begin
                logic [15:0] s;
                int last;
                bit loc, bad;
                logic [31:0] a;
                s    = ltr_wr ? ltr_sel : seg_val;
                loc  = !ltr_wr && s[2];
                last = int'(s[15:3]) * 8 + 7;
                bad  = loc ? (last > int'(m_llim)) : (last > int'(m_gsize));
                a    = (loc ? m_lbase : m_gbase) + 32'(int'(s[15:3]) * 8);
                if (bad) e_fault = 1;
                else begin
                    m_busy = 2; p_ltr = ltr_wr; p_idx = seg_idx; p_sel = s;
                    p_lo = mem[a[11:2]]; p_hi = mem[a[11:2] + 10'd1];
                end
            end else if (seg_wr && !prot_en) begin
                m_val[seg_idx] = seg_val; m_base[seg_idx] = 32'(seg_val) << 4;
                m_lim[seg_idx] = 20'h0FFFF; m_attr[seg_idx] = '0;
            end
            if (gtr_wr) begin
                m_gbase = gtr_base; m_gsize = gtr_size;
            end
        end
    end

    // Cycle comparison of the model against the ports.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            tests++;
            if (busy !== (m_busy > 0) || fault !== e_fault || xl_valid !== e_valid ||
                (e_valid && {xl_addr, xl_limit, xl_attr} !== {e_addr, e_lim, e_attr})) begin
                fails++;
                $display("FAIL %s cycle: busy=%0b fault=%0b valid=%0b addr=%h lim=%h attr=%h exp busy=%0b fault=%0b valid=%0b addr=%h lim=%h attr=%h",
                         tag, busy, fault, xl_valid, xl_addr, xl_limit, xl_attr,
                         m_busy > 0, e_fault, e_valid, e_addr, e_lim, e_attr);
            end
        end
    end

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic seg_load(input logic [1:0] idx, input logic [15:0] v, output bit f);
        seg_idx = idx; seg_val = v; seg_wr = 1'b1;
        @(negedge clk);
        seg_wr = 1'b0;
        f = fault;
        while (busy) @(negedge clk);
    endtask

    task automatic ltr_load(input logic [15:0] v, output bit f);
        ltr_sel = v; ltr_wr = 1'b1;
        @(negedge clk);
        ltr_wr = 1'b0;
        f = fault;
        while (busy) @(negedge clk);
    endtask

    task automatic xlate(input logic [1:0] s, input logic [31:0] off, output logic [31:0] a);
        xl_seg = s; xl_off = off; xl_req = 1'b1;
        @(negedge clk);
        xl_req = 1'b0;
        chk(xl_valid === 1'b1, "R10 valid after one cycle", 32'(xl_valid), 32'd1);
        a = xl_addr;
    endtask

    task automatic gtr_set(input logic [31:0] b, input logic [15:0] s);
        gtr_base = b; gtr_size = s; gtr_wr = 1'b1;
        @(negedge clk);
        gtr_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        bit f;
        int n0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) begin
            mem[64 + 2*i]     = 32'h1000_0000 + 32'(i) * 32'h0001_1000;
            mem[64 + 2*i + 1] = {12'h0A0 + 12'(i), 20'(i * 16 + 15)};
        end
        mem[64 + 10] = 32'h0000_0800; mem[64 + 11] = 32'h0000_0017;  // entry 5: local table
        mem[64 + 14] = 32'hFFFF_FF00;                                 // entry 7: near the top
        for (int j = 0; j < 4; j++) begin
            mem[512 + 2*j]     = 32'h2000_0000 + 32'(j) * 32'h100;
            mem[512 + 2*j + 1] = {12'h0B0 + 12'(j), 20'h00FFF};
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R9";
        chk(!busy && !fault && !xl_valid && !mem_rd, "R9 reset outputs",
            {28'h0, busy, fault, xl_valid, mem_rd}, 32'h0);
        prot_en = 1'b1;
        xlate(2'd0, 32'h0000_1234, a);
        chk(a == 32'h0000_1234, "R9 cached base zero", a, 32'h0000_1234);
        ltr_load(16'h0008, f);
        chk(f == 1'b1, "R9 global size zero faults", 32'(f), 32'd1);
        seg_load(2'd1, 16'h0004, f);
        chk(f == 1'b1, "R9 local limit zero faults", 32'(f), 32'd1);

        tag = "R1";
        prot_en = 1'b0;
        seg_load(2'd1, 16'h1234, f);
        xlate(2'd1, 32'hABCD_0010, a);
        chk(a == 32'h0001_2350, "R1 shift and add", a, 32'h0001_2350);
        chk(xl_limit == 20'h0FFFF, "R1 limit", 32'(xl_limit), 32'h0FFFF);
        seg_load(2'd3, 16'hFFFF, f);
        xlate(2'd3, 32'h0000_FFFF, a);
        chk(a == 32'h0000_FFEF, "R1 20-bit wrap", a, 32'h0000_FFEF);

        tag = "R3";
        gtr_set(32'h0000_0100, 16'h003F);
        prot_en = 1'b1;
        rd_log.delete();
        seg_load(2'd2, 16'h001B, f);
        chk(rd_log.size() == 2, "R3 two reads", 32'(rd_log.size()), 32'd2);
        if (rd_log.size() == 2) begin
            chk(rd_log[0] == 32'h118, "R3 low word address", rd_log[0], 32'h118);
            chk(rd_log[1] == 32'h11C, "R3 high word address", rd_log[1], 32'h11C);
        end
        tag = "R2";
        xlate(2'd2, 32'h0000_0010, a);
        chk(a == 32'h1003_3010, "R2 base plus offset", a, 32'h1003_3010);
        chk({xl_attr, xl_limit} == {12'h0A3, 20'h0003F}, "R3 limit and attributes",
            {xl_attr, xl_limit}, {12'h0A3, 20'h0003F});
        seg_load(2'd0, 16'h0038, f);
        chk(f == 1'b0, "R7 last entry accepted", 32'(f), 32'd0);
        xlate(2'd0, 32'h0000_0200, a);
        chk(a == 32'h0000_0100, "R2 32-bit wrap", a, 32'h0000_0100);

        tag = "R7";
        rd_log.delete();
        seg_load(2'd1, 16'h0040, f);
        chk(f == 1'b1, "R7 past global size", 32'(f), 32'd1);
        chk(rd_log.size() == 0, "R7 no read on fault", 32'(rd_log.size()), 32'd0);
        xlate(2'd1, 32'h0000_0007, a);
        chk(a == 32'h0001_2347, "R7 cache kept", a, 32'h0001_2347);

        tag = "R5";
        rd_log.delete();
        ltr_load(16'h002C, f);
        chk(rd_log.size() > 0 && rd_log[0] == 32'h128, "R5 lookup in global table",
            rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h128);
        tag = "R4";
        rd_log.delete();
        seg_load(2'd3, 16'h000C, f);
        chk(rd_log.size() > 0 && rd_log[0] == 32'h808, "R4 local table address",
            rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h808);
        xlate(2'd3, 32'h0000_0005, a);
        chk(a == 32'h2000_0105, "R4 local base", a, 32'h2000_0105);
        seg_load(2'd3, 16'h001C, f);
        chk(f == 1'b1, "R7 past local limit", 32'(f), 32'd1);
        seg_load(2'd3, 16'h0014, f);
        chk(f == 1'b0, "R7 local limit boundary", 32'(f), 32'd0);

        tag = "R6";
        seg_idx = 2'd0; seg_val = 16'h0008; seg_wr = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy first cycle", 32'(busy), 32'd1);
        seg_idx = 2'd1; seg_val = 16'h0010; xl_req = 1'b1; xl_seg = 2'd2; xl_off = '0;
        @(negedge clk);
        seg_wr = 1'b0; xl_req = 1'b0;
        chk(busy == 1'b1 && xl_valid == 1'b0, "R6 stalled request",
            {30'h0, busy, xl_valid}, 32'h2);
        @(negedge clk);
        chk(busy == 1'b0 && xl_valid == 1'b0, "R6 busy falls, no result",
            {30'h0, busy, xl_valid}, 32'h0);
        xlate(2'd1, 32'h0000_0000, a);
        chk(a == 32'h0001_2340, "R6 dropped write", a, 32'h0001_2340);

        tag = "R8";
        mem[64 + 6] = 32'hDEAD_0000;
        n0 = rd_count;
        xlate(2'd2, 32'h0000_0010, a);
        chk(a == 32'h1003_3010, "R8 cached copy used", a, 32'h1003_3010);
        chk(rd_count == n0, "R8 no read on translate", 32'(rd_count), 32'(n0));

        tag = "R11";
        rd_log.delete();
        ltr_sel = 16'h0028; ltr_wr = 1'b1;
        seg_idx = 2'd2; seg_val = 16'h0008; seg_wr = 1'b1;
        @(negedge clk);
        ltr_wr = 1'b0; seg_wr = 1'b0;
        while (busy) @(negedge clk);
        chk(rd_log.size() > 0 && rd_log[0] == 32'h128, "R11 local load taken",
            rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h128);
        xlate(2'd2, 32'h0000_0010, a);
        chk(a == 32'h1003_3010, "R11 segment write dropped", a, 32'h1003_3010);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule